// File: doc/BRIEF.md
# Standby Pin Retention Status Register

This block keeps, for a group of pins on one GPIO port, a record of whether output retention is in force for each pin while the chip is in standby. When the standby-entry pulse arrives, every pin whose retention enable is high at that moment has its status bit set by hardware. The bit stays set until software writes a zero to it. Writing a one does nothing. Hardware setting wins over a software clear that lands in the same cycle.

The status bits are reached through a simple register bus at a single word address. Reads return data one cycle after the request. Writes take effect on the strobe cycle. Each bit is also screened against the access attributes. A non-secure access to a pin marked secure sees that bit as zero and cannot clear it. When the relevant privilege control is on, an unprivileged access gets the same treatment. The secure-side control covers secure pins and the non-secure-side control covers the rest. A blocked access is simply masked: the bus has no error or fault signal. The status vector is also driven straight out of the block to the retention logic.

Top module: `ioret_status_reg`

## Requirements
- R1: After reset every status bit is 0 and the read data output is 0.
- R2: A one-cycle pulse on `standby_enter` sets the status bit of each pin whose `pin_ret_en` bit is 1 in that cycle. Pins whose enable is 0 keep their previous value.
- R3: A status bit rises only on a standby pulse. Changing `pin_ret_en` without a pulse, including dropping it to 0, leaves every status bit unchanged.
- R4: A permitted write to the register address clears status bit i when write-data bit PIN_LO+i is 0. A write-data bit of 1 leaves that status bit unchanged.
- R5: If a standby pulse with pin i enabled and a permitted clear of bit i fall in the same cycle, bit i ends set.
- R6: For a pin whose `pin_secure` bit is 1, an access with `bus_secure`=0 reads that bit as 0, and a write of 0 to it leaves it set.
- R7: An access with `bus_priv`=0 reads as 0 and cannot clear a bit in two cases: a secure pin while `spriv_ctl`=1, and a non-secure pin while `nspriv_ctl`=1. With the controls at 0, unprivileged accesses are allowed.
- R8: Status bit i sits at read/write data bit PIN_LO+i (defaults: pins at bits 13, 14 and 15). All other data bits read as 0. Reads and writes at any address other than REG_ADDR read 0 and change nothing.
- R9: Read data appears on `bus_rdata` on the clock edge after the cycle in which `bus_rd` is high. It shows the status as it stood in the request cycle. In a cycle with no read request, `bus_rdata` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read request |
| bus_secure | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | DATA_W | Registered read data |
| pin_ret_en | input | NUM_PINS | Per-pin standby retention enable |
| pin_secure | input | NUM_PINS | Per-pin security attribute |
| spriv_ctl | input | 1 | Privilege protection for secure pins |
| nspriv_ctl | input | 1 | Privilege protection for non-secure pins |
| standby_enter | input | 1 | Single-cycle standby-entry pulse |
| ret_status | output | NUM_PINS | Current retention status per pin |

## Verification
The bench builds the block with its default parameters: three pins starting at data bit 13, a 32-bit data path and an 8-bit address. This places the status field in the middle of the word, so every read is compared as a whole 32-bit value. Any bit that leaks outside bits 13 to 15, or a field shifted by one position, shows up as a miscompare. With three pins, a single vector can mix secure and non-secure pins, and set and cleared bits. That lets each read check per-bit masking against both privilege controls at once.

// File: rtl/ioret_pkg.sv
package ioret_pkg;

    // Attributes carried by one bus access
    typedef struct packed {
        logic secure;
        logic priv;
    } bus_attr_t;

    // Whether one pin's bit is visible to an access with the given attributes
    function automatic logic pin_access_ok(
        input logic      pin_is_secure,
        input logic      secure_priv_on,
        input logic      nonsec_priv_on,
        input bus_attr_t attr
    );
        logic need_priv;
        logic sec_ok;
        logic priv_ok;
        need_priv = pin_is_secure ? secure_priv_on : nonsec_priv_on;
        sec_ok    = !pin_is_secure || attr.secure;
        priv_ok   = !need_priv || attr.priv;
        return sec_ok && priv_ok;
    endfunction

endpackage

// File: rtl/ioret_addr_decode.sv
module ioret_addr_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h2C
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output logic              rd_hit_o,
    output logic              wr_hit_o
);
    logic match;

    always_comb begin
        match    = (addr_i == REG_ADDR);
        rd_hit_o = rd_i && match;
        wr_hit_o = wr_i && match;
    end
endmodule

// File: rtl/ioret_pin_gate.sv
module ioret_pin_gate
    import ioret_pkg::*;
#(
    parameter int unsigned NUM_PINS = 3
) (
    input  logic [NUM_PINS-1:0] pin_secure_i,
    input  logic                spriv_i,
    input  logic                nspriv_i,
    input  bus_attr_t           attr_i,
    output logic [NUM_PINS-1:0] allow_o
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        always_comb begin
            allow_o[g] = pin_access_ok(pin_secure_i[g], spriv_i, nspriv_i, attr_i);
        end
    end
endmodule

// File: rtl/ioret_status_cell.sv
module ioret_status_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic status_o
);
    typedef struct packed {
        logic ret;
    } cell_t;

    cell_t cell_d;
    cell_t cell_q;

    always_comb begin
        cell_d = cell_q;
        if (clr_i) begin
            cell_d.ret = 1'b0;
        end
        // hardware set wins over a same-cycle clear
        if (set_i) begin
            cell_d.ret = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign status_o = cell_q.ret;
endmodule

// File: rtl/ioret_status_reg.sv
module ioret_status_reg
    import ioret_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h2C,
    parameter int unsigned NUM_PINS = 3,
    parameter int unsigned PIN_LO   = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic                bus_secure,
    input  logic                bus_priv,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_ret_en,
    input  logic [NUM_PINS-1:0] pin_secure,
    input  logic                spriv_ctl,
    input  logic                nspriv_ctl,
    input  logic                standby_enter,
    output logic [NUM_PINS-1:0] ret_status
);
    localparam int unsigned PIN_HI = PIN_LO + NUM_PINS - 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    bus_attr_t           attr;
    logic                rd_hit;
    logic                wr_hit;
    logic [NUM_PINS-1:0] allow;
    logic [NUM_PINS-1:0] wfield;
    logic [NUM_PINS-1:0] set_req;
    logic [NUM_PINS-1:0] clr_req;
    logic                wdata_unused;
    rd_state_t           rd_d;
    rd_state_t           rd_q;

    initial begin
        if (PIN_HI >= DATA_W) begin
            $error("status field does not fit in the data word");
        end
    end

    assign attr.secure  = bus_secure;
    assign attr.priv    = bus_priv;
    assign wfield       = bus_wdata[PIN_HI:PIN_LO];
    assign wdata_unused = &{1'b0, bus_wdata};

    ioret_addr_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_decode (
        .addr_i   (bus_addr),
        .rd_i     (bus_rd),
        .wr_i     (bus_wr),
        .rd_hit_o (rd_hit),
        .wr_hit_o (wr_hit)
    );

    ioret_pin_gate #(
        .NUM_PINS (NUM_PINS)
    ) u_gate (
        .pin_secure_i (pin_secure),
        .spriv_i      (spriv_ctl),
        .nspriv_i     (nspriv_ctl),
        .attr_i       (attr),
        .allow_o      (allow)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_cell
        always_comb begin
            set_req[g] = standby_enter && pin_ret_en[g];
            clr_req[g] = wr_hit && allow[g] && !wfield[g];
        end

        ioret_status_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_req[g]),
            .clr_i    (clr_req[g]),
            .status_o (ret_status[g])
        );
    end

    always_comb begin
        rd_d       = '0;
        if (rd_hit) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                rd_d.rdata[PIN_LO + i] = ret_status[i] && allow[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;
endmodule

// File: rtl/ioret_status_chk.sv
module ioret_status_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_PINS = 3,
    parameter int unsigned PIN_LO   = 13
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic                bus_secure,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_ret_en,
    input logic [NUM_PINS-1:0] pin_secure,
    input logic                standby_enter,
    input logic [NUM_PINS-1:0] ret_status
);
    localparam logic [DATA_W-1:0] FIELD_MASK =
        ((DATA_W'(1) << NUM_PINS) - DATA_W'(1)) << PIN_LO;

    logic [DATA_W-1:0] secure_bits;
    logic              addr_unused;
    assign secure_bits = DATA_W'(pin_secure) << PIN_LO;
    assign addr_unused = &{1'b0, bus_addr};

    // R1 / R9: no read request means zero read data after the edge
    assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == '0));

    // R2: enabled pins are set after a standby pulse
    assert_standby_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        standby_enter |=> ((ret_status & $past(pin_ret_en)) == $past(pin_ret_en)));

    // R3: bits only rise after a standby pulse
    assert_rise_needs_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ret_status & ~$past(ret_status)) != '0) |-> $past(standby_enter));

    // R4: bits only fall after a write
    assert_fall_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ret_status & $past(ret_status)) != '0) |-> $past(bus_wr));

    // R6: non-secure read returns zero on secure pins
    assert_nonsec_raz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && !bus_secure) |-> ((bus_rdata & $past(secure_bits)) == '0));

    // R8: nothing outside the status field is ever driven
    assert_field_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & ~FIELD_MASK) == '0));
endmodule

bind ioret_status_reg ioret_status_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_PINS (NUM_PINS),
    .PIN_LO   (PIN_LO)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_secure    (bus_secure),
    .bus_rdata     (bus_rdata),
    .pin_ret_en    (pin_ret_en),
    .pin_secure    (pin_secure),
    .standby_enter (standby_enter),
    .ret_status    (ret_status)
);

// File: tb/tb_ioret_status_reg.sv
module tb_ioret_status_reg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 8;
    localparam logic [7:0]  REG_ADDR = 8'h2C;
    localparam int unsigned NUM_PINS = 3;
    localparam int unsigned PIN_LO   = 13;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [DATA_W-1:0]   bus_wdata = '0;
    logic                bus_wr = 1'b0;
    logic                bus_rd = 1'b0;
    logic                bus_secure = 1'b0;
    logic                bus_priv = 1'b0;
    logic [DATA_W-1:0]   bus_rdata;
    logic [NUM_PINS-1:0] pin_ret_en = '0;
    logic [NUM_PINS-1:0] pin_secure = '0;
    logic                spriv_ctl = 1'b0;
    logic                nspriv_ctl = 1'b0;
    logic                standby_enter = 1'b0;
    logic [NUM_PINS-1:0] ret_status;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ioret_status_reg #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
        .NUM_PINS(NUM_PINS), .PIN_LO(PIN_LO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_secure(bus_secure),
        .bus_priv(bus_priv), .bus_rdata(bus_rdata), .pin_ret_en(pin_ret_en),
        .pin_secure(pin_secure), .spriv_ctl(spriv_ctl), .nspriv_ctl(nspriv_ctl),
        .standby_enter(standby_enter), .ret_status(ret_status)
    );

    function automatic logic [DATA_W-1:0] fld(input logic [NUM_PINS-1:0] v);
        return DATA_W'(v) << PIN_LO;
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                             input logic sec, input logic prv);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_secure = sec; bus_priv = prv; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic sec,
                            input logic prv, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_secure = sec; bus_priv = prv; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic standby(input logic [NUM_PINS-1:0] en);
        @(negedge clk);
        pin_ret_en = en; standby_enter = 1'b1;
        @(negedge clk);
        standby_enter = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", DATA_W'(ret_status), '0);
        check("R1 rdata", bus_rdata, '0);
    endtask

    task automatic t_set();
        logic [DATA_W-1:0] d;
        standby(3'b101);
        check("R2 set", DATA_W'(ret_status), DATA_W'(3'b101));
        bus_read(REG_ADDR, 1'b1, 1'b1, d);
        check("R9 R8 read", d, fld(3'b101));
        @(negedge clk);
        check("R9 idle", bus_rdata, '0);
    endtask

    task automatic t_hold();
        @(negedge clk);
        pin_ret_en = 3'b010;
        repeat (2) @(negedge clk);
        check("R3 enable change", DATA_W'(ret_status), DATA_W'(3'b101));
        pin_ret_en = 3'b000;
        @(negedge clk);
        check("R3 enable drop", DATA_W'(ret_status), DATA_W'(3'b101));
        standby(3'b000);
        check("R2 disabled pulse", DATA_W'(ret_status), DATA_W'(3'b101));
    endtask

    task automatic t_clear();
        bus_write(REG_ADDR, fld(3'b110), 1'b1, 1'b1);
        check("R4 clear", DATA_W'(ret_status), DATA_W'(3'b100));
        bus_write(REG_ADDR, '1, 1'b1, 1'b1);
        check("R4 write one", DATA_W'(ret_status), DATA_W'(3'b100));
    endtask

    task automatic t_priority();
        @(negedge clk);
        pin_ret_en = 3'b011; standby_enter = 1'b1;
        bus_addr = REG_ADDR; bus_wdata = '0; bus_secure = 1'b1; bus_priv = 1'b1;
        bus_wr = 1'b1;
        @(negedge clk);
        standby_enter = 1'b0; bus_wr = 1'b0;
        check("R5 set wins", DATA_W'(ret_status), DATA_W'(3'b011));
    endtask

    task automatic t_secure();
        logic [DATA_W-1:0] d;
        standby(3'b111);
        pin_secure = 3'b001;
        bus_read(REG_ADDR, 1'b0, 1'b1, d);
        check("R6 nonsecure read", d, fld(3'b110));
        bus_write(REG_ADDR, '0, 1'b0, 1'b1);
        check("R6 nonsecure write", DATA_W'(ret_status), DATA_W'(3'b001));
        bus_write(REG_ADDR, '0, 1'b1, 1'b1);
        check("R6 secure write", DATA_W'(ret_status), DATA_W'(3'b000));
    endtask

    task automatic t_priv();
        logic [DATA_W-1:0] d;
        standby(3'b111);
        pin_secure = 3'b001; spriv_ctl = 1'b1; nspriv_ctl = 1'b0;
        bus_read(REG_ADDR, 1'b1, 1'b0, d);
        check("R7 secure unpriv read", d, fld(3'b110));
        bus_read(REG_ADDR, 1'b1, 1'b1, d);
        check("R7 secure priv read", d, fld(3'b111));
        nspriv_ctl = 1'b1;
        bus_read(REG_ADDR, 1'b0, 1'b1, d);
        check("R7 nonsecure priv read", d, fld(3'b110));
        bus_read(REG_ADDR, 1'b0, 1'b0, d);
        check("R7 nonsecure unpriv read", d, '0);
        bus_write(REG_ADDR, '0, 1'b1, 1'b0);
        check("R7 unpriv write", DATA_W'(ret_status), DATA_W'(3'b111));
        spriv_ctl = 1'b0; nspriv_ctl = 1'b0;
        bus_write(REG_ADDR, fld(3'b011), 1'b1, 1'b0);
        check("R7 controls off", DATA_W'(ret_status), DATA_W'(3'b011));
    endtask

    task automatic t_addr();
        logic [DATA_W-1:0] d;
        bus_write(REG_ADDR + 8'h4, '0, 1'b1, 1'b1);
        check("R8 other addr write", DATA_W'(ret_status), DATA_W'(3'b011));
        bus_read(REG_ADDR + 8'h4, 1'b1, 1'b1, d);
        check("R8 other addr read", d, '0);
        bus_read(REG_ADDR, 1'b1, 1'b1, d);
        check("R8 field position", d, fld(3'b011));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_hold();
        t_clear();
        t_priority();
        t_secure();
        t_priv();
        t_addr();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule